// File: doc/BRIEF.md
# Eight-Channel Descriptor-Ring DMA Register Front End

This block is the software-visible register file and ring-pointer tracker of a descriptor-ring DMA engine with eight channels. Software reaches it over a plain 32-bit memory-mapped bus with separate write and read strobes. Read data comes back one cycle after the read strobe, marked by a valid flag. The block keeps one global control word, which holds an owner bit and an enable bit for every channel, and a bank of per-channel registers. Each bank holds the interrupt masks, the software head index, the hardware tail index, the ring base address, the ring size, the completion count, and the error state.

The descriptor fetch and data-move engine is not part of this block. It reports a finished descriptor by pulsing that channel's `done` input. The block then advances the tail and the completion counter and raises the channel's interrupt line. The interrupt is cleared through the `irq_ack` inputs. Channels are either device-owned or host-owned, and the owner decides which of the two mask bits in the channel's control register applies. A base address that breaks the 64-byte alignment rule is flagged in the channel's error register.

The bus map is as follows. Channel n's bank starts at byte address n*0x40. The global control word sits just above the last bank, at 0x200.

Top module: `dmar_top`

## Requirements
- R1: After reset, every stored register reads 0 and every `irq` bit is low. The only nonzero field is the status word's quiesce bit 29, which reads 1 because every channel is disabled.
- R2: The global control word at 0x200 holds, for channel n, the owner at bit 2n (0 = device, 1 = host) and the enable at bit 2n+1. Bits 31:16 read 0, and the word changes only when it is written.
- R3: Per-channel registers sit at base n*0x40 plus these offsets: 0 control, 4 head, 8 tail, 20 ring address low, 24 ring address high, 32 status, 44 error, 48 error mask. The head stores bits 16:0. Ring address high stores bits 26:0, and its size field is bits 20:4.
- R4: A bus write to the tail register has no effect on it.
- R5: A `done` pulse on an enabled channel whose tail differs from its head does two things. It increments the tail, and the tail becomes 0 when the incremented value reaches or exceeds the ring size. In the same cycle it increments the completion count, status bits 16:0, modulo 2^17.
- R6: A `done` pulse changes neither the tail nor the count when the channel's enable bit is clear, or when its tail equals its head.
- R7: Status bit 28 reads 1 while the channel is enabled and its tail differs from its head. Status bit 29 reads 1 while the channel is disabled.
- R8: Every accepted `done` makes an interrupt pending. While the pending flag is set and the owner's mask bit is clear, `irq[n]` is high. A device-owned channel uses control bit 24 and a host-owned channel uses control bit 25. The pending flag stays set until an `irq_ack[n]` pulse clears it.
- R9: Setting the applicable mask bit drops `irq[n]` and leaves the interrupt pending. Clearing the mask bit raises `irq[n]` again. The mask bit that does not apply to the channel's owner has no effect.
- R10: A write to ring address low stores the value with bits 5:0 forced to 0. If any of those bits were set, the write also sets error bit 0, which stays set until a 1 is written to error bit 0. While error bit 0 is set and error-mask bit 0 is clear, `irq[n]` is high.
- R11: Offsets that are not mapped, and addresses that are neither a bank nor the global word, read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 10 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid one cycle after `bus_rd` |
| bus_rvalid | output | 1 | Read data valid |
| done | input | 8 | Per-channel descriptor-finished pulse |
| irq_ack | input | 8 | Per-channel interrupt acknowledge pulse |
| irq | output | 8 | Per-channel interrupt, registered |

## Verification
Assertions inside each channel check four rules on every cycle: an accepted `done` moves the tail by exactly one step or wraps it to zero, and it moves the count by exactly one; the tail never moves in any other cycle; a pending interrupt survives until it is acknowledged; and the alignment error stays set until software clears it. A global assertion checks that the control word changes only on a write. The bench scenarios show the behaviour that no single-cycle property captures. These are the bus address decode and read-back widths, the wrap at a chosen ring size, the choice of mask bit by owner, the mask-off-then-on re-arm, and the fact that tail writes and unmapped writes leave no trace in the read-back state.

// File: rtl/dmar_pkg.sv
package dmar_pkg;
  localparam int WORD_W     = 32;
  localparam int IDX_W      = 17;
  localparam int STRIDE     = 64;
  localparam int OFF_W      = 6;
  localparam int ALIGN_BITS = 6;

  localparam logic [OFF_W-1:0] OFF_CTRL = 6'd0;
  localparam logic [OFF_W-1:0] OFF_HEAD = 6'd4;
  localparam logic [OFF_W-1:0] OFF_TAIL = 6'd8;
  localparam logic [OFF_W-1:0] OFF_RLO  = 6'd20;
  localparam logic [OFF_W-1:0] OFF_RHI  = 6'd24;
  localparam logic [OFF_W-1:0] OFF_STAT = 6'd32;
  localparam logic [OFF_W-1:0] OFF_ERR  = 6'd44;
  localparam logic [OFF_W-1:0] OFF_EMSK = 6'd48;

  localparam int MSK_DEV_BIT  = 24;
  localparam int RHI_W        = 27;
  localparam int RHI_SIZE_LSB = 4;
endpackage

// File: rtl/dmar_glob.sv
module dmar_glob #(
  parameter int NCH = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr,
  input  logic [2*NCH-1:0] wdata,
  output logic [2*NCH-1:0] word,
  output logic [NCH-1:0] own,
  output logic [NCH-1:0] en
);
  logic [2*NCH-1:0] word_q;

  always_ff @(posedge clk) begin
    if (rst) word_q <= '0;
    else if (wr) word_q <= wdata;
  end

  assign word = word_q;

  for (genvar n = 0; n < NCH; n++) begin : g_split
    assign own[n] = word_q[2*n];
    assign en[n]  = word_q[2*n+1];
  end

  assert_glob_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !wr |=> $stable(word_q));
endmodule

// File: rtl/dmar_chan.sv
module dmar_chan
  import dmar_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [OFF_W-1:0]  off,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rd_data,
  input  logic              own,
  input  logic              en,
  input  logic              done,
  input  logic              ack,
  output logic              irq
);
  logic [1:0]        msk_q;
  logic [IDX_W-1:0]  head_q, tail_q, cnt_q;
  logic [WORD_W-1:0] rlo_q;
  logic [RHI_W-1:0]  rhi_q;
  logic              err_q, emsk_q, pend_q, irq_q;

  logic [IDX_W-1:0]  ring_size;
  logic [IDX_W:0]    tail_inc;
  logic              done_ok, mask_eff, busy;

  assign ring_size = rhi_q[RHI_SIZE_LSB +: IDX_W];
  assign tail_inc  = {1'b0, tail_q} + 1'b1;
  assign done_ok   = done && en && (tail_q != head_q);
  assign mask_eff  = own ? msk_q[1] : msk_q[0];
  assign busy      = en && (tail_q != head_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      msk_q  <= '0;
      head_q <= '0;
      rlo_q  <= '0;
      rhi_q  <= '0;
      err_q  <= 1'b0;
      emsk_q <= 1'b0;
    end else if (wr_en) begin
      unique case (off)
        OFF_CTRL: msk_q  <= wdata[MSK_DEV_BIT +: 2];
        OFF_HEAD: head_q <= wdata[IDX_W-1:0];
        OFF_RLO: begin
          rlo_q <= {wdata[WORD_W-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
          if (wdata[ALIGN_BITS-1:0] != '0) err_q <= 1'b1;
        end
        OFF_RHI:  rhi_q  <= wdata[RHI_W-1:0];
        OFF_ERR:  if (wdata[0]) err_q <= 1'b0;
        OFF_EMSK: emsk_q <= wdata[0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tail_q <= '0;
      cnt_q  <= '0;
      pend_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (done_ok) begin
        tail_q <= (tail_inc >= {1'b0, ring_size}) ? '0 : tail_inc[IDX_W-1:0];
        cnt_q  <= cnt_q + 1'b1;
      end
      if (done_ok) pend_q <= 1'b1;
      else if (ack) pend_q <= 1'b0;
      irq_q <= (pend_q && !mask_eff) || (err_q && !emsk_q);
    end
  end

  assign irq = irq_q;

  always_comb begin
    unique case (off)
      OFF_CTRL: rd_data = {6'd0, msk_q, 24'd0};
      OFF_HEAD: rd_data = WORD_W'(head_q);
      OFF_TAIL: rd_data = WORD_W'(tail_q);
      OFF_RLO:  rd_data = rlo_q;
      OFF_RHI:  rd_data = WORD_W'(rhi_q);
      OFF_STAT: rd_data = {2'b00, !en, busy, 11'd0, cnt_q};
      OFF_ERR:  rd_data = WORD_W'(err_q);
      OFF_EMSK: rd_data = WORD_W'(emsk_q);
      default:  rd_data = '0;
    endcase
  end

  assert_tail_step_R5: assert property (@(posedge clk) disable iff (rst)
    done_ok |=> (tail_q == '0 || tail_q == $past(tail_q) + 1'b1));
  assert_cnt_step_R5: assert property (@(posedge clk) disable iff (rst)
    done_ok |=> cnt_q == $past(cnt_q) + 1'b1);
  assert_tail_frozen_R6: assert property (@(posedge clk) disable iff (rst)
    !done_ok |=> tail_q == $past(tail_q));
  assert_pend_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (pend_q && !ack) |=> pend_q);
  assert_err_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    (err_q && !(wr_en && off == OFF_ERR && wdata[0])) |=> err_q);
endmodule

// File: rtl/dmar_top.sv
module dmar_top
  import dmar_pkg::*;
#(
  parameter int NCH    = 8,
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  output logic              bus_rvalid,
  input  logic [NCH-1:0]    done,
  input  logic [NCH-1:0]    irq_ack,
  output logic [NCH-1:0]    irq
);
  localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1;
  localparam logic [ADDR_W-1:0] CH_SPAN = ADDR_W'(NCH * STRIDE);

  logic              ch_hit, glob_hit;
  logic [CH_W-1:0]   ch_idx;
  logic [2*NCH-1:0]  glob_word;
  logic [NCH-1:0]    own, en;
  logic [WORD_W-1:0] ch_rd [NCH];
  logic [WORD_W-1:0] rd_nxt, rdata_q;
  logic              rvalid_q;

  assign ch_hit   = bus_addr < CH_SPAN;
  assign glob_hit = bus_addr == CH_SPAN;
  assign ch_idx   = bus_addr[OFF_W +: CH_W];

  dmar_glob #(.NCH(NCH)) u_glob (
    .clk  (clk),
    .rst  (rst),
    .wr   (bus_wr && glob_hit),
    .wdata(bus_wdata[2*NCH-1:0]),
    .word (glob_word),
    .own  (own),
    .en   (en)
  );

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    dmar_chan u_chan (
      .clk    (clk),
      .rst    (rst),
      .wr_en  (bus_wr && ch_hit && ch_idx == CH_W'(n)),
      .off    (bus_addr[OFF_W-1:0]),
      .wdata  (bus_wdata),
      .rd_data(ch_rd[n]),
      .own    (own[n]),
      .en     (en[n]),
      .done   (done[n]),
      .ack    (irq_ack[n]),
      .irq    (irq[n])
    );
  end

  always_comb begin
    if (ch_hit)        rd_nxt = ch_rd[ch_idx];
    else if (glob_hit) rd_nxt = WORD_W'(glob_word);
    else               rd_nxt = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= bus_rd;
      if (bus_rd) rdata_q <= rd_nxt;
    end
  end

  assign bus_rdata  = rdata_q;
  assign bus_rvalid = rvalid_q;
endmodule

// File: tb/tb_dmar_top.sv
`timescale 1ns/100ps
module tb_dmar_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [9:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic [7:0]  done = '0, irq_ack = '0;
  logic [7:0]  irq;

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  dmar_top dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .done(done), .irq_ack(irq_ack), .irq(irq)
  );

  // monitor: pop expected read data as the design returns it
  always @(negedge clk) begin
    if (!rst && bus_rvalid) begin
      n_cmp++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL unexpected read data %h (expected none)", bus_rdata);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (bus_rdata !== e) begin
          n_bad++;
          $display("FAIL %s: got %h expected %h", t, bus_rdata, e);
        end
      end
    end
  end

  task automatic wr32(input logic [9:0] a, input logic [31:0] d);
    @(posedge clk); #1 bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1 bus_wr = 1'b0;
  endtask

  task automatic rd_exp(input logic [9:0] a, input logic [31:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(posedge clk); #1 bus_rd = 1'b1; bus_addr = a;
    @(posedge clk); #1 bus_rd = 1'b0;
    @(posedge clk); #1;
  endtask

  task automatic pulse_done(input int ch);
    @(posedge clk); #1 done[ch] = 1'b1;
    @(posedge clk); #1 done[ch] = 1'b0;
  endtask

  task automatic pulse_ack(input int ch);
    @(posedge clk); #1 irq_ack[ch] = 1'b1;
    @(posedge clk); #1 irq_ack[ch] = 1'b0;
  endtask

  task automatic chk_irq(input int ch, input logic e, input string t);
    repeat (2) @(posedge clk);
    #1;
    n_cmp++;
    if (irq[ch] !== e) begin
      n_bad++;
      $display("FAIL %s: irq[%0d] got %b expected %b", t, ch, irq[ch], e);
    end
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  localparam logic [9:0] GLOB = 10'h200;
  function automatic logic [9:0] ra(input int ch, input int off);
    return 10'(ch * 64 + off);
  endfunction

  initial begin
    #100000;
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog expired (got hang, expected completion)");
    finish_run();
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;

    // R1 reset state
    rd_exp(GLOB, 32'h0, "R1 global reset");
    rd_exp(ra(0, 4), 32'h0, "R1 head reset");
    rd_exp(ra(0, 32), 32'h2000_0000, "R1 status reset quiesce");
    chk_irq(0, 1'b0, "R1 irq reset");

    // R2 owner/enable pairs: ch2 enable (bit5), ch5 host (bit10) + enable (bit11)
    wr32(GLOB, 32'hABCD_0C20);
    rd_exp(GLOB, 32'h0000_0C20, "R2 global readback");

    // R3 widths and stride
    wr32(ra(2, 4), 32'hFFFF_FFFF);
    rd_exp(ra(2, 4), 32'h0001_FFFF, "R3 head width");
    wr32(ra(2, 24), 32'hFFFF_FFFF);
    rd_exp(ra(2, 24), 32'h07FF_FFFF, "R3 ring high width");
    rd_exp(ra(3, 24), 32'h0, "R3 neighbour bank untouched");
    wr32(ra(2, 24), 32'h0000_0030);   // ring size 3
    wr32(ra(2, 4), 32'd2);

    // R4 tail not writable
    wr32(ra(2, 8), 32'd5);
    rd_exp(ra(2, 8), 32'h0, "R4 tail write ignored");

    // R7 busy
    rd_exp(ra(2, 32), 32'h1000_0000, "R7 busy while tail!=head");

    // R5 advance
    pulse_done(2);
    pulse_done(2);
    rd_exp(ra(2, 8), 32'd2, "R5 tail after two done");
    rd_exp(ra(2, 32), 32'd2, "R5 R7 count 2, idle");

    // R8 interrupt raised, held, acked
    chk_irq(2, 1'b1, "R8 device irq raised");
    chk_irq(2, 1'b1, "R8 irq held");
    pulse_ack(2);
    chk_irq(2, 1'b0, "R8 irq cleared by ack");

    // R5 wrap at ring size
    wr32(ra(2, 4), 32'd0);
    pulse_done(2);
    rd_exp(ra(2, 8), 32'd0, "R5 tail wraps to 0");
    // R6 tail==head ignored
    pulse_done(2);
    rd_exp(ra(2, 32), 32'd3, "R6 done ignored when tail==head");
    pulse_ack(2);
    chk_irq(2, 1'b0, "R8 ack after wrap");

    // R6 disabled channel
    wr32(ra(0, 4), 32'd4);
    pulse_done(0);
    rd_exp(ra(0, 8), 32'd0, "R6 disabled tail frozen");
    rd_exp(ra(0, 32), 32'h2000_0000, "R6 disabled count frozen");
    chk_irq(0, 1'b0, "R6 no irq on disabled");

    // R8 R9 host-owned ch5: bit24 does not apply
    wr32(ra(5, 24), 32'h0000_0100);   // size 16
    wr32(ra(5, 4), 32'd5);
    wr32(ra(5, 0), 32'h0100_0000);
    pulse_done(5);
    chk_irq(5, 1'b1, "R8 host ignores device mask");
    wr32(ra(5, 0), 32'h0300_0000);
    rd_exp(ra(5, 0), 32'h0300_0000, "R3 control readback");
    chk_irq(5, 1'b0, "R9 host mask hides irq");
    wr32(ra(5, 0), 32'h0);
    chk_irq(5, 1'b1, "R9 host unmask re-arms");
    pulse_ack(5);
    chk_irq(5, 1'b0, "R8 host ack");

    // R9 device-owned ch2: bit24 masks, clearing re-arms
    wr32(ra(2, 4), 32'd1);
    wr32(ra(2, 0), 32'h0100_0000);
    pulse_done(2);
    rd_exp(ra(2, 8), 32'd1, "R5 tail step with mask set");
    chk_irq(2, 1'b0, "R9 device mask hides irq");
    wr32(ra(2, 0), 32'h0);
    chk_irq(2, 1'b1, "R9 device unmask re-arms");
    pulse_ack(2);

    // R10 alignment error
    wr32(ra(3, 20), 32'h1234_5678);
    rd_exp(ra(3, 20), 32'h1234_5640, "R10 low bits forced zero");
    rd_exp(ra(3, 44), 32'd1, "R10 error set");
    chk_irq(3, 1'b1, "R10 error irq");
    wr32(ra(3, 48), 32'd1);
    chk_irq(3, 1'b0, "R10 error irq masked");
    wr32(ra(3, 44), 32'd1);
    rd_exp(ra(3, 44), 32'd0, "R10 error cleared");
    wr32(ra(4, 20), 32'h0000_0040);
    rd_exp(ra(4, 44), 32'd0, "R10 aligned write no error");

    // R11 unmapped
    wr32(ra(2, 12), 32'hFFFF_FFFF);
    rd_exp(ra(2, 12), 32'h0, "R11 unmapped offset");
    wr32(10'h204, 32'hFFFF_FFFF);
    rd_exp(10'h204, 32'h0, "R11 unmapped address");
    rd_exp(GLOB, 32'h0000_0C20, "R11 global untouched");

    repeat (4) @(posedge clk);
    if (exp_q.size() != 0) begin
      n_cmp++;
      n_bad++;
      $display("FAIL reads outstanding: got %0d expected 0", exp_q.size());
    end
    finish_run();
  end
endmodule